// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This block is a 16-bit counter with a 16-bit reload/capture register that can work in several modes. A register port selects the mode. It can capture the count on a falling trigger edge. It can auto-reload while counting up, or count up and down with the trigger pin setting the direction. It can generate a baud clock for a serial port, and it can drive a square-wave clock output. The counter steps either on a machine-cycle tick or on the falling edges of an external count input. The baud and clock-out modes use a faster state tick instead of the machine-cycle tick.

The block sits in a single clock domain. Its clock-enable strobes (`mcTick`, `stTick`) come from a shared prescaler. Software programs the block through a byte-wide write port and reads it back through a combinational read port. The outputs are two sticky flags and their combined interrupt request, a serial clock pulse every sixteenth baud rollover, and the clock-out level.

Register map (byte addresses): 0 control, 1 mode, 2 count low, 3 count high, 4 reload/capture low, 5 reload/capture high.
- **Control byte:** bit7 overflow flag, bit6 external flag, bit5 receive-baud enable, bit4 transmit-baud enable, bit3 trigger enable, bit2 run, bit1 counter select (1 = count input edges), bit0 capture select.
- **Mode byte:** bit1 clock-out enable, bit0 down-count enable.

Top module: `mm_timer16`

## Requirements
- R1: After reset, the control, mode, count and reload bytes read 0x00, and `irq`, `clkOut` and `serTick` are 0.
- R2: With run = 1 and counter select = 0, outside the baud and clock-out modes, the count advances by one for each `mcTick`, and `stTick` has no effect. With run = 0 the count holds.
- R3: With counter select = 1, the block samples `cntIn` on each `mcTick`. The count advances once when a high sample is followed by a low sample. Level changes between ticks are not seen.
- R4: In capture mode (capture select = 1, both baud enables 0), stepping from 0xFFFF gives 0x0000 and sets the overflow flag. With trigger enable = 1, a falling edge on `trigIn` copies the count into the reload register and sets the external flag.
- R5: In up-only auto-reload (capture select = 0, down enable = 0), stepping from 0xFFFF loads the reload value and sets the overflow flag. With trigger enable = 1, a falling `trigIn` edge also loads the reload value and sets the external flag.
- R6: With down enable = 1 in auto-reload mode, `trigIn` = 1 counts up and `trigIn` = 0 counts down.
  - Counting down, a step taken while the count equals the reload value loads 0xFFFF.
  - Counting up, a step from 0xFFFF loads the reload value.
  - Both cases set the overflow flag.
- R7: With down enable = 1, the external flag toggles on every rollover in either direction and is kept out of `irq`.
- R8: With either baud enable set, the count advances on `stTick` only and reloads on rollover without setting the overflow flag. A falling `trigIn` edge with trigger enable = 1 sets the external flag and leaves the count unchanged.
- R9: In baud mode, `serTick` pulses for one clock in the cycle after every sixteenth rollover.
- R10: With clock-out enable = 1 and counter select = 0, the count advances on `stTick` and reloads on rollover. `clkOut` toggles on each rollover, and the overflow flag is not set.
- R11: `irq` is high when the overflow flag is set, or when the external flag is set and down enable is 0.
- R12: Flags change from software only through a control-byte write. If a hardware set and a software write of 0 fall in the same clock, the hardware set wins.
- R13: A write to a count byte takes effect at the next clock edge. It replaces any hardware step or reload in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mcTick | input | 1 | Machine-cycle enable pulse |
| stTick | input | 1 | State-time enable pulse |
| cntIn | input | 1 | External count input |
| trigIn | input | 1 | Trigger / direction input |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write byte address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read byte address |
| rdData | output | 8 | Read data (combinational) |
| irq | output | 1 | Interrupt request |
| ovfFlag | output | 1 | Overflow flag |
| extFlag | output | 1 | External flag |
| serTick | output | 1 | Serial clock pulse (baud rollovers / 16) |
| clkOut | output | 1 | Square-wave clock output |

## Verification
The assertions assume the following about the inputs:
- `mcTick`, `stTick`, `cntIn` and `trigIn` are already synchronous to `clk`.
- Each tick is a single-cycle strobe.
- Software changes the mode only while no rollover is pending in that cycle.

The stimulus follows these assumptions. Every input is driven on the falling clock edge, and each tick is raised for exactly one cycle. Trigger edges are made by holding `trigIn` high for a full cycle before dropping it. Mode changes are always made between ticks. The only exceptions are the deliberate same-cycle races for R12 and R13.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTLO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNTHI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAPLO = 3'd4;
  localparam logic [ADDR_W-1:0] A_CAPHI = 3'd5;

  typedef struct packed {
    logic step;        // advance the count this clock
    logic countUp;     // direction of the step
    logic rollReload;  // rollover loads the reload value (else wraps to zero)
    logic trigCapture; // copy count into reload register
    logic trigReload;  // force count <= reload value
  } mmtStrobe_t;
endpackage

// File: rtl/mmt_ctrl.sv
module mmt_ctrl
  import mmt_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SER_DIV_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcTick,
  input  logic              stTick,
  input  logic              cntIn,
  input  logic              trigIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rollEvt,
  output mmtStrobe_t        stb,
  output logic [DATA_W-1:0] ctrlByte,
  output logic [DATA_W-1:0] modeByte,
  output logic              irq,
  output logic              tf,
  output logic              exf,
  output logic              serTick,
  output logic              clkOut
);
  localparam logic [SER_DIV_W-1:0] DIV_LAST = '1;

  logic rxClkEn, txClkEn, extEn, run, cntSel, capSel;
  logic downEn, outEn;
  logic cntSamp, trigPrev;
  logic [SER_DIV_W-1:0] serDiv;

  logic wrCtrl, wrMode;
  logic baudMode, clkOutMode, fastMode, reloadMode, updownMode;
  logic cntFall, trigFall, trigHit, tfSet, exfToggle;
  logic tfNext, exfNext;

  assign wrCtrl = wrEn && (wrAddr == A_CTRL);
  assign wrMode = wrEn && (wrAddr == A_MODE);

  // mode decode
  assign baudMode   = rxClkEn | txClkEn;
  assign clkOutMode = outEn & ~cntSel;
  assign fastMode   = baudMode | clkOutMode;
  assign reloadMode = ~baudMode & ~capSel;
  assign updownMode = reloadMode & downEn;

  // input edge detection
  assign cntFall  = mcTick & cntSamp & ~cntIn;
  assign trigFall = trigPrev & ~trigIn;
  assign trigHit  = trigFall & extEn & ~updownMode;

  always_comb begin
    stb             = '0;
    stb.step        = run & (cntSel ? cntFall : (fastMode ? stTick : mcTick));
    stb.countUp     = ~updownMode | trigIn;
    stb.rollReload  = baudMode | ~capSel;
    stb.trigCapture = trigHit & capSel & ~baudMode;
    stb.trigReload  = trigHit & reloadMode;
  end

  assign tfSet     = rollEvt & ~baudMode & ~clkOutMode;
  assign exfToggle = rollEvt & updownMode;

  always_comb begin
    tfNext  = tf;
    exfNext = exf;
    if (wrCtrl) begin
      tfNext  = wrData[7];
      exfNext = wrData[6];
    end
    if (tfSet)     tfNext  = 1'b1;
    if (trigHit)   exfNext = 1'b1;
    if (exfToggle) exfNext = ~exf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {rxClkEn, txClkEn, extEn, run, cntSel, capSel} <= '0;
      {outEn, downEn} <= '0;
      tf       <= 1'b0;
      exf      <= 1'b0;
      cntSamp  <= 1'b0;
      trigPrev <= 1'b0;
      serDiv   <= '0;
      serTick  <= 1'b0;
      clkOut   <= 1'b0;
    end else begin
      tf       <= tfNext;
      exf      <= exfNext;
      trigPrev <= trigIn;
      if (mcTick) cntSamp <= cntIn;
      if (wrCtrl) {rxClkEn, txClkEn, extEn, run, cntSel, capSel} <= wrData[5:0];
      if (wrMode) {outEn, downEn} <= wrData[1:0];
      serTick <= 1'b0;
      if (rollEvt && baudMode) begin
        serDiv  <= serDiv + 1'b1;
        serTick <= (serDiv == DIV_LAST);
      end
      if (rollEvt && clkOutMode) clkOut <= ~clkOut;
    end
  end

  assign irq      = tf | (exf & ~downEn);
  assign ctrlByte = DATA_W'({tf, exf, rxClkEn, txClkEn, extEn, run, cntSel, capSel});
  assign modeByte = DATA_W'({outEn, downEn});

  // R8: a baud rollover never raises the overflow flag
  p_baud_no_tf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (baudMode && !tf && !wrCtrl) |=> !tf);
  // R10: the clock-out level moves only on a rollover in clock-out mode
  p_clkout_steady_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(rollEvt && clkOutMode) |=> $stable(clkOut));
  // R9: a serial pulse always follows a baud rollover
  p_sertick_after_roll_r9: assert property (@(posedge clk) disable iff (!rstN)
    serTick |-> $past(baudMode && rollEvt));
  // R12: a hardware set beats a same-cycle software clear
  p_hw_set_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    tfSet |=> tf);
endmodule

// File: rtl/mmt_dp.sv
module mmt_dp
  import mmt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  mmtStrobe_t          stb,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  output logic [2*DATA_W-1:0] cnt,
  output logic [2*DATA_W-1:0] cap,
  output logic                rollEvt
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [1:0] cntWr, capWr;
  logic upRoll, dnRoll, hwActive;
  logic [CNT_W-1:0] hwNext;

  assign cntWr = {wrEn && (wrAddr == A_CNTHI), wrEn && (wrAddr == A_CNTLO)};
  assign capWr = {wrEn && (wrAddr == A_CAPHI), wrEn && (wrAddr == A_CAPLO)};

  // a software count write or a trigger reload overrides a step
  assign hwActive = stb.step & ~stb.trigReload & ~|cntWr;
  assign upRoll   = hwActive &  stb.countUp & (cnt == ALL_ONES);
  assign dnRoll   = hwActive & ~stb.countUp & (cnt == cap);
  assign rollEvt  = upRoll | dnRoll;

  always_comb begin
    hwNext = cnt;
    if (stb.trigReload)  hwNext = cap;
    else if (upRoll)     hwNext = stb.rollReload ? cap : '0;
    else if (dnRoll)     hwNext = ALL_ONES;
    else if (stb.step)   hwNext = stb.countUp ? cnt + 1'b1 : cnt - 1'b1;
  end

  for (genvar b = 0; b < 2; b++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[b*DATA_W +: DATA_W] <= '0;
        cap[b*DATA_W +: DATA_W] <= '0;
      end else begin
        if (cntWr[b])      cnt[b*DATA_W +: DATA_W] <= wrData;
        else if (~|cntWr)  cnt[b*DATA_W +: DATA_W] <= hwNext[b*DATA_W +: DATA_W];
        if (capWr[b])      cap[b*DATA_W +: DATA_W] <= wrData;
        else if (stb.trigCapture && ~|capWr)
                           cap[b*DATA_W +: DATA_W] <= cnt[b*DATA_W +: DATA_W];
      end
    end
  end

  // R2: a plain step advances the count by exactly one
  p_step_plus_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(hwActive && stb.countUp && !upRoll) |-> cnt == $past(cnt) + 1'b1);
  // R6: a down rollover lands on all ones
  p_underflow_max_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(dnRoll) |-> cnt == ALL_ONES);
  // R4: a capture copies the count seen in the trigger cycle
  p_capture_copy_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.trigCapture && ~|capWr) |-> cap == $past(cnt));
endmodule

// File: rtl/mm_timer16.sv
module mm_timer16
  import mmt_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SER_DIV_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcTick,
  input  logic              stTick,
  input  logic              cntIn,
  input  logic              trigIn,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              ovfFlag,
  output logic              extFlag,
  output logic              serTick,
  output logic              clkOut
);
  localparam int CNT_W = 2 * DATA_W;

  mmtStrobe_t        stb;
  logic              rollEvt;
  logic [CNT_W-1:0]  cnt, cap;
  logic [DATA_W-1:0] ctrlByte, modeByte;

  mmt_ctrl #(.DATA_W(DATA_W), .SER_DIV_W(SER_DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .mcTick(mcTick), .stTick(stTick),
    .cntIn(cntIn), .trigIn(trigIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rollEvt(rollEvt), .stb(stb), .ctrlByte(ctrlByte),
    .modeByte(modeByte), .irq(irq), .tf(ovfFlag), .exf(extFlag),
    .serTick(serTick), .clkOut(clkOut)
  );

  mmt_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cnt(cnt), .cap(cap), .rollEvt(rollEvt)
  );

  always_comb begin
    unique case (rdAddr)
      A_CTRL:  rdData = ctrlByte;
      A_MODE:  rdData = modeByte;
      A_CNTLO: rdData = cnt[DATA_W-1:0];
      A_CNTHI: rdData = cnt[CNT_W-1:DATA_W];
      A_CAPLO: rdData = cap[DATA_W-1:0];
      A_CAPHI: rdData = cap[CNT_W-1:DATA_W];
      default: rdData = '0;
    endcase
  end

  // R11: in up/down mode only the overflow flag can hold the request high
  p_irq_updown_r11: assert property (@(posedge clk) disable iff (!rstN)
    (modeByte[0] && irq) |-> ovfFlag);
endmodule

// File: tb/sim_mm_timer16.sv
module sim_mm_timer16;
  logic clk = 1'b0, rstN = 1'b0;
  logic mcTick = 0, stTick = 0, cntIn = 0, trigIn = 0, wrEn = 0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0, rdData;
  logic irq, ovfFlag, extFlag, serTick, clkOut;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mm_timer16 u0 (.clk(clk), .rstN(rstN), .mcTick(mcTick), .stTick(stTick),
    .cntIn(cntIn), .trigIn(trigIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq),
    .ovfFlag(ovfFlag), .extFlag(extFlag), .serTick(serTick), .clkOut(clkOut));

  task automatic check(string tag, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic rdCnt(output int v);
    logic [7:0] lo, hi;
    rd(2, lo); rd(3, hi); v = {hi, lo};
  endtask

  task automatic rdCap(output int v);
    logic [7:0] lo, hi;
    rd(4, lo); rd(5, hi); v = {hi, lo};
  endtask

  task automatic setCnt(input logic [15:0] v);
    wr(2, v[7:0]); wr(3, v[15:8]);
  endtask

  task automatic setCap(input logic [15:0] v);
    wr(4, v[7:0]); wr(5, v[15:8]);
  endtask

  task automatic tick(input logic mc, input logic st);
    mcTick = mc; stTick = st;
    @(negedge clk); mcTick = 0; stTick = 0;
  endtask

  task automatic trigFallEdge();
    trigIn = 1; @(negedge clk);
    trigIn = 0; @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], d); check("R1 reg", d, 0);
    end
    check("R1 irq", irq, 0); check("R1 clkOut", clkOut, 0); check("R1 serTick", serTick, 0);
  endtask

  task automatic testTimer();
    int v;
    setCnt(16'h0010); wr(0, 8'h04);
    repeat (3) tick(1, 0);
    rdCnt(v); check("R2 three ticks", v, 16'h0013);
    tick(0, 1); rdCnt(v); check("R2 state tick ignored", v, 16'h0013);
    wr(0, 8'h00); tick(1, 0); rdCnt(v); check("R2 stopped holds", v, 16'h0013);
  endtask

  task automatic testCounter();
    int v;
    setCnt(16'h0000); wr(0, 8'h06);
    cntIn = 1; tick(1, 0); rdCnt(v); check("R3 high sample no step", v, 0);
    cntIn = 0; tick(1, 0); rdCnt(v); check("R3 fall counts", v, 1);
    tick(1, 0); rdCnt(v); check("R3 low hold no step", v, 1);
    cntIn = 1; @(negedge clk); cntIn = 0; @(negedge clk);
    tick(1, 0); rdCnt(v); check("R3 pulse between ticks unseen", v, 1);
    wr(0, 8'h00);
  endtask

  task automatic testCapture();
    int v; logic [7:0] d;
    setCnt(16'hFFFE); wr(0, 8'h0D);
    tick(1, 0); tick(1, 0);
    rdCnt(v); check("R4 wrap to zero", v, 0);
    rd(0, d); check("R4 overflow flag", d, 8'h8D); check("R11 irq from tf", irq, 1);
    repeat (5) tick(1, 0);
    trigFallEdge();
    rdCap(v); check("R4 captured count", v, 5);
    rd(0, d); check("R4 external flag", d, 8'hCD);
    wr(0, 8'h0D); rd(0, d); check("R12 software clear", d, 8'h0D);
    check("R11 irq low after clear", irq, 0);
    wr(0, 8'h00);
  endtask

  task automatic testReload();
    int v; logic [7:0] d;
    setCap(16'h1234); setCnt(16'hFFFF); wr(0, 8'h0C);
    tick(1, 0); rdCnt(v); check("R5 overflow reload", v, 16'h1234);
    rd(0, d); check("R5 overflow flag", d, 8'h8C);
    tick(1, 0); tick(1, 0);
    trigFallEdge();
    rdCnt(v); check("R5 trigger reload", v, 16'h1234);
    rd(0, d); check("R5 external flag", d, 8'hCC);
    wr(0, 8'h00);
  endtask

  task automatic testUpDown();
    int v; logic [7:0] d;
    wr(1, 8'h01); setCap(16'h0100); setCnt(16'h0101); trigIn = 0;
    @(negedge clk); wr(0, 8'h04);
    tick(1, 0); rdCnt(v); check("R6 count down", v, 16'h0100);
    tick(1, 0); rdCnt(v); check("R6 underflow loads max", v, 16'hFFFF);
    rd(0, d); check("R7 flags after underflow", d, 8'hC4);
    wr(0, 8'h44); check("R7 external flag masked", irq, 0);
    trigIn = 1; tick(1, 0);
    rdCnt(v); check("R6 up overflow reload", v, 16'h0100);
    rd(0, d); check("R7 toggle back", d, 8'h84);
    wr(0, 8'h00); wr(1, 8'h00); trigIn = 0; @(negedge clk);
  endtask

  task automatic testBaud();
    int v; logic [7:0] d;
    setCap(16'hFFFE); setCnt(16'hFFFE); wr(0, 8'h1C);
    tick(0, 1); rdCnt(v); check("R8 state tick steps", v, 16'hFFFF);
    tick(1, 0); rdCnt(v); check("R8 machine tick ignored", v, 16'hFFFF);
    tick(0, 1); rdCnt(v); check("R8 rollover reload", v, 16'hFFFE);
    rd(0, d); check("R8 no overflow flag", d, 8'h1C);
    trigFallEdge();
    rd(0, d); check("R8 trigger sets ext", d, 8'h5C);
    rdCnt(v); check("R8 trigger no reload", v, 16'hFFFE);
    for (int i = 2; i <= 15; i++) begin
      tick(0, 1); tick(0, 1);
      check("R9 no early serial tick", serTick, 0);
    end
    tick(0, 1); tick(0, 1);
    check("R9 sixteenth rollover pulse", serTick, 1);
    tick(0, 0); check("R9 pulse one clock", serTick, 0);
    wr(0, 8'h00);
  endtask

  task automatic testClkOut();
    int v; logic [7:0] d;
    wr(1, 8'h02); setCap(16'hFFFD); setCnt(16'hFFFD); wr(0, 8'h04);
    tick(0, 1); tick(1, 0); tick(0, 1);
    rdCnt(v); check("R10 steps on state tick only", v, 16'hFFFF);
    check("R10 no toggle yet", clkOut, 0);
    tick(0, 1); check("R10 toggle high", clkOut, 1);
    rd(0, d); check("R10 no overflow flag", d, 8'h04);
    repeat (3) tick(0, 1); check("R10 toggle low", clkOut, 0);
    wr(0, 8'h00); wr(1, 8'h00);
  endtask

  task automatic testRaces();
    int v; logic [7:0] d;
    setCap(16'h0000); setCnt(16'hFFFF); wr(0, 8'h04);
    wrEn = 1; wrAddr = 0; wrData = 8'h04; mcTick = 1;
    @(negedge clk); wrEn = 0; mcTick = 0;
    rd(0, d); check("R12 hardware set wins", d, 8'h84);
    wr(0, 8'h04); rd(0, d); check("R12 clear alone", d, 8'h04);
    setCnt(16'h0020);
    wrEn = 1; wrAddr = 2; wrData = 8'h50; mcTick = 1;
    rdAddr = 2; #1; check("R13 not before edge", rdData, 8'h20);
    @(negedge clk); wrEn = 0; mcTick = 0;
    rdCnt(v); check("R13 write beats step", v, 16'h0050);
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1; @(negedge clk);
    testReset(); testTimer(); testCounter(); testCapture();
    testReload(); testUpDown(); testBaud(); testClkOut(); testRaces();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1; nChk++; nBad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule